// File: doc/BRIEF.md
# Link Port Event Selector

This block sits beside one port of a point-to-point link and turns the port's raw per-cycle event strobes into a single increment pulse for an external performance counter. A 32-bit configuration word chooses which events matter. The events come from three groups. The first is a set of eight single-bit port events: transmitted flits, idle flits, queue overflow and occupancy, and received special or corrupted flits. The second is the end-of-transmit queue, with its allocations tagged by message class and its not-empty level. The third is the arbitration-select allocations, tagged by class.

The pulse is the OR of every enabled source, registered once, so it rises in the cycle after the qualifying strobe. A cycle in which several sources fire still yields one pulse. End-of-transmit allocations of one chosen message class can be reported in two ways. They can be reported one for one. They can also be thinned by an internal 7-bit rolling prescaler, so that one pulse marks every 128 matching allocations. Software writes the configuration word through a plain write strobe and reads it back on a read-data bus.

Top module: `link_evt_sel`

## Requirements
- R1: While reset is asserted and after its release, `cfg_rdata` reads 0 and `inc_pulse` is 0 until an enabled event occurs.
- R2: A write with `cfg_we` high stores `cfg_wdata` from the next cycle on. Bits 31:24 and 21:9 are stored and read back as written. Bits 23:22 and 8:0 always read 0 and ignore writes.
- R3: Each config bit from 31 down to 24 enables one port strobe. The order is `ev_flit_tx` (31), `ev_null_tx` (30), `ev_retryq_ovf` (29), `ev_retryq_busy` (28), `ev_outq_ovf` (27), `ev_outq_busy` (26), `ev_spec_rx` (25) and `ev_crc_rx` (24). An enabled strobe in cycle t gives `inc_pulse` high in cycle t+1.
- R4: A strobe whose enable bit is 0 produces no pulse.
- R5: With bit 21 set, each cycle with `eot_alloc_vld` high and `eot_alloc_cls` equal to bits 20:17 gives a pulse in the next cycle. The valid codes are 1 to 8: 1 home VN0, 2 home VN1, 3 non-data response, 4 data response VN0, 5 snoop, 6 non-coherent bypass, 7 non-coherent standard, 8 data response VN1.
- R6: With bit 21 clear, matching allocations advance a 7-bit rolling count. Only the allocation that wraps it from 127 to 0 pulses, which is the 128th match counted from reset or from the last write. Non-matching allocations do not advance the count.
- R7: A selected code of 0 or 9 to 15 matches no allocation, in either mode.
- R8: With bit 16 set, every cycle in which `eot_busy` is high gives a pulse in the next cycle.
- R9: Config bits 15:9 mask the `arb_alloc` vector, with bit 9+i paired with `arb_alloc[i]`. Bit 6 is home VN0, bit 5 home VN1, bit 4 snoop, bit 3 non-data response, bit 2 data response of either VN, bit 1 non-coherent standard and bit 0 non-coherent bypass. Any allocation whose mask bit is set pulses in the next cycle.
- R10: `inc_pulse` is one bit per cycle. Several sources firing in the same cycle give one high cycle, and the pulse falls in the cycle after all sources go quiet.
- R11: A configuration write clears the rolling count. Events in the write cycle itself are judged against the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Stored configuration, reserved bits zero |
| ev_flit_tx | input | 1 | Flit transmitted |
| ev_null_tx | input | 1 | Idle flit transmitted |
| ev_retryq_ovf | input | 1 | Retry queue overflow |
| ev_retryq_busy | input | 1 | Retry queue holds entries |
| ev_outq_ovf | input | 1 | Output queue overflow |
| ev_outq_busy | input | 1 | Output queue holds entries |
| ev_spec_rx | input | 1 | Special flit received |
| ev_crc_rx | input | 1 | Flit received with CRC error |
| eot_alloc_vld | input | 1 | Allocation into end-of-transmit queue |
| eot_alloc_cls | input | 4 | Message-class code of that allocation |
| eot_busy | input | 1 | End-of-transmit queue not empty |
| arb_alloc | input | 7 | Arbitration-select allocations, one bit per class |
| inc_pulse | output | 1 | Increment pulse to the counter |

## Verification
Each event source reaches `inc_pulse` through exactly one register. So a strobe driven in cycle t must show on the pulse in cycle t+1, and a write at edge e shows on `cfg_rdata` right after e. The bench drives inputs on the falling edge and lets one rising edge pass. It then samples on the next falling edge against a reference model that is advanced at that same rising edge. The rolling count is tracked by the model across hundreds of cycles, so the 128th match and the effect of a mid-count rewrite are checked on the exact cycle they fall due.

// File: rtl/lpes_pkg.sv
package lpes_pkg;
  localparam int CFG_W      = 32;
  localparam int N_PORT_EV  = 8;
  localparam int N_ARB      = 7;
  localparam int MC_W       = 4;

  // field positions are decoded by software, so they are fixed
  localparam int PORT_LO    = 24;
  localparam int EVERY_BIT  = 21;
  localparam int MC_LO      = 17;
  localparam int BUSY_BIT   = 16;
  localparam int ARB_LO     = 9;

  localparam logic [MC_W-1:0] MC_FIRST = 4'd1;
  localparam logic [MC_W-1:0] MC_LAST  = 4'd8;

  localparam logic [CFG_W-1:0] CFG_WMASK = {8'hFF, 2'b00, 13'h1FFF, 9'h000};

  typedef struct packed {
    logic [N_PORT_EV-1:0] port_en;
    logic                 every;
    logic [MC_W-1:0]      mc_sel;
    logic                 busy_en;
    logic [N_ARB-1:0]     arb_mask;
  } cfg_t;

  function automatic cfg_t cfg_decode(input logic [CFG_W-1:0] w);
    cfg_t c;
    c.port_en  = w[PORT_LO +: N_PORT_EV];
    c.every    = w[EVERY_BIT];
    c.mc_sel   = w[MC_LO +: MC_W];
    c.busy_en  = w[BUSY_BIT];
    c.arb_mask = w[ARB_LO +: N_ARB];
    return c;
  endfunction
endpackage

// File: rtl/lpes_cfg_reg.sv
module lpes_cfg_reg #(
  parameter int                W     = 32,
  parameter logic [W-1:0]      WMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= q_d;
  end
endmodule

// File: rtl/lpes_mc_prescaler.sv
module lpes_mc_prescaler #(
  parameter int                CNT_W    = 7,
  parameter int                MC_W     = 4,
  parameter logic [MC_W-1:0]   MC_FIRST = 1,
  parameter logic [MC_W-1:0]   MC_LAST  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            alloc_vld,
  input  logic [MC_W-1:0] alloc_cls,
  input  logic [MC_W-1:0] sel,
  input  logic            every,
  output logic            hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt, cnt_d;
  logic             cnt_en;
  logic             sel_ok, match, wrap;

  always_comb begin
    sel_ok = (sel >= MC_FIRST) && (sel <= MC_LAST);
    match  = alloc_vld && sel_ok && (alloc_cls == sel);
    wrap   = match && !every && (cnt == CNT_MAX);
    hit    = every ? match : wrap;
    cnt_en = clr || (match && !every);
    cnt_d  = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/lpes_evt_merge.sv
module lpes_evt_merge #(
  parameter int N_PORT = 8,
  parameter int N_ARB  = 7
) (
  input  logic [N_PORT-1:0] port_ev,
  input  logic [N_PORT-1:0] port_en,
  input  logic              busy,
  input  logic              busy_en,
  input  logic [N_ARB-1:0]  arb_vec,
  input  logic [N_ARB-1:0]  arb_mask,
  input  logic              mc_hit,
  output logic              any
);
  logic [N_PORT-1:0] port_g;
  logic [N_ARB-1:0]  arb_g;

  for (genvar g = 0; g < N_PORT; g++) begin : g_port
    assign port_g[g] = port_ev[g] & port_en[g];
  end
  for (genvar a = 0; a < N_ARB; a++) begin : g_arb
    assign arb_g[a] = arb_vec[a] & arb_mask[a];
  end

  always_comb begin
    any = (|port_g) | (busy & busy_en) | (|arb_g) | mc_hit;
  end
endmodule

// File: rtl/link_evt_sel.sv
module link_evt_sel
  import lpes_pkg::*;
#(
  parameter int PRESCALE_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_rdata,
  input  logic                ev_flit_tx,
  input  logic                ev_null_tx,
  input  logic                ev_retryq_ovf,
  input  logic                ev_retryq_busy,
  input  logic                ev_outq_ovf,
  input  logic                ev_outq_busy,
  input  logic                ev_spec_rx,
  input  logic                ev_crc_rx,
  input  logic                eot_alloc_vld,
  input  logic [MC_W-1:0]     eot_alloc_cls,
  input  logic                eot_busy,
  input  logic [N_ARB-1:0]    arb_alloc,
  output logic                inc_pulse
);
  logic [CFG_W-1:0]     cfg_q;
  cfg_t                 cfg;
  logic [N_PORT_EV-1:0] port_ev;
  logic                 mc_hit;
  logic                 any_ev;
  logic                 pulse_d;

  lpes_cfg_reg #(.W(CFG_W), .WMASK(CFG_WMASK)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
  );

  always_comb begin
    cfg       = cfg_decode(cfg_q);
    cfg_rdata = cfg_q;
    port_ev   = {ev_flit_tx, ev_null_tx, ev_retryq_ovf, ev_retryq_busy,
                 ev_outq_ovf, ev_outq_busy, ev_spec_rx, ev_crc_rx};
  end

  lpes_mc_prescaler #(
    .CNT_W(PRESCALE_W), .MC_W(MC_W), .MC_FIRST(MC_FIRST), .MC_LAST(MC_LAST)
  ) u_mc (
    .clk(clk), .rst_n(rst_n), .clr(cfg_we),
    .alloc_vld(eot_alloc_vld), .alloc_cls(eot_alloc_cls),
    .sel(cfg.mc_sel), .every(cfg.every), .hit(mc_hit)
  );

  lpes_evt_merge #(.N_PORT(N_PORT_EV), .N_ARB(N_ARB)) u_merge (
    .port_ev(port_ev), .port_en(cfg.port_en),
    .busy(eot_busy), .busy_en(cfg.busy_en),
    .arb_vec(arb_alloc), .arb_mask(cfg.arb_mask),
    .mc_hit(mc_hit), .any(any_ev)
  );

  always_comb begin
    pulse_d = any_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inc_pulse <= 1'b0;
    else        inc_pulse <= pulse_d;
  end
endmodule

// File: rtl/link_evt_sel_chk.sv
module link_evt_sel_chk
  import lpes_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             ev_flit_tx,
  input logic             ev_null_tx,
  input logic             ev_retryq_ovf,
  input logic             ev_retryq_busy,
  input logic             ev_outq_ovf,
  input logic             ev_outq_busy,
  input logic             ev_spec_rx,
  input logic             ev_crc_rx,
  input logic             eot_alloc_vld,
  input logic [MC_W-1:0]  eot_alloc_cls,
  input logic             eot_busy,
  input logic [N_ARB-1:0] arb_alloc,
  input logic             inc_pulse
);
  logic [N_PORT_EV-1:0] pv;
  logic                 mc_ok;
  assign pv    = {ev_flit_tx, ev_null_tx, ev_retryq_ovf, ev_retryq_busy,
                  ev_outq_ovf, ev_outq_busy, ev_spec_rx, ev_crc_rx};
  assign mc_ok = (eot_alloc_cls >= MC_FIRST) && (eot_alloc_cls <= MC_LAST);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (inc_pulse == 1'b0 && cfg_rdata == '0);
    end
  end

  a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && $past(rst_n)) |-> (cfg_rdata == ($past(cfg_wdata) & CFG_WMASK)));

  a_r3_port_event: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pv & cfg_rdata[PORT_LO +: N_PORT_EV])) |=> inc_pulse);

  a_r4_quiet_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(pv & cfg_rdata[PORT_LO +: N_PORT_EV])) && !(eot_busy && cfg_rdata[BUSY_BIT])
     && !(|(arb_alloc & cfg_rdata[ARB_LO +: N_ARB])) && !eot_alloc_vld) |=> !inc_pulse);

  a_r5_every_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_alloc_vld && mc_ok && cfg_rdata[EVERY_BIT]
     && eot_alloc_cls == cfg_rdata[MC_LO +: MC_W]) |=> inc_pulse);

  a_r8_busy_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_busy && cfg_rdata[BUSY_BIT]) |=> inc_pulse);

  a_r9_arb_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (|(arb_alloc & cfg_rdata[ARB_LO +: N_ARB])) |=> inc_pulse);
endmodule

bind link_evt_sel link_evt_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .ev_flit_tx(ev_flit_tx), .ev_null_tx(ev_null_tx),
  .ev_retryq_ovf(ev_retryq_ovf), .ev_retryq_busy(ev_retryq_busy),
  .ev_outq_ovf(ev_outq_ovf), .ev_outq_busy(ev_outq_busy),
  .ev_spec_rx(ev_spec_rx), .ev_crc_rx(ev_crc_rx),
  .eot_alloc_vld(eot_alloc_vld), .eot_alloc_cls(eot_alloc_cls),
  .eot_busy(eot_busy), .arb_alloc(arb_alloc), .inc_pulse(inc_pulse)
);

// File: tb/link_evt_sel_tb.sv
module link_evt_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  pev = '0;
  logic        eot_alloc_vld = 1'b0;
  logic [3:0]  eot_alloc_cls = '0;
  logic        eot_busy = 1'b0;
  logic [6:0]  arb_alloc = '0;
  logic        inc_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit [31:0] m_cfg = '0;
  bit [6:0]  m_pre = '0;

  localparam bit [31:0] WMASK = 32'hFF3F_FE00;

  always #10 clk = ~clk;

  link_evt_sel u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .ev_flit_tx(pev[7]), .ev_null_tx(pev[6]), .ev_retryq_ovf(pev[5]),
    .ev_retryq_busy(pev[4]), .ev_outq_ovf(pev[3]), .ev_outq_busy(pev[2]),
    .ev_spec_rx(pev[1]), .ev_crc_rx(pev[0]),
    .eot_alloc_vld(eot_alloc_vld), .eot_alloc_cls(eot_alloc_cls),
    .eot_busy(eot_busy), .arb_alloc(arb_alloc), .inc_pulse(inc_pulse)
  );

  function automatic bit m_match();
    bit [3:0] s = m_cfg[20:17];
    return eot_alloc_vld && s >= 4'd1 && s <= 4'd8 && eot_alloc_cls == s;
  endfunction

  function automatic bit m_pulse();
    bit mc = m_cfg[21] ? m_match() : (m_match() && m_pre == 7'd127);
    return (|(pev & m_cfg[31:24])) || (eot_busy && m_cfg[16])
           || (|(arb_alloc & m_cfg[15:9])) || mc;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(string req);
    bit exp = m_pulse();
    bit mt  = m_match();
    @(posedge clk);
    if (cfg_we) begin
      m_pre = '0;
      m_cfg = cfg_wdata & WMASK;
    end else if (mt && !m_cfg[21]) begin
      m_pre = m_pre + 7'd1;
    end
    @(negedge clk);
    chk(req, {31'd0, inc_pulse}, {31'd0, exp});
  endtask

  task automatic quiet();
    pev = '0; eot_alloc_vld = 0; eot_alloc_cls = '0; eot_busy = 0;
    arb_alloc = '0; cfg_we = 0;
  endtask

  task automatic set_cfg(logic [31:0] v, string req);
    quiet();
    cfg_we = 1; cfg_wdata = v;
    step(req);
    cfg_we = 0;
    chk(req, cfg_rdata, v & WMASK);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    chk("R1", cfg_rdata, 32'h0);
    chk("R1", {31'd0, inc_pulse}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    // R1: still zero after release with no events enabled
    pev = 8'hFF; eot_busy = 1; arb_alloc = 7'h7F; step("R1");
    quiet();

    // R2: reserved bits read zero
    set_cfg(32'hFFFF_FFFF, "R2");
    set_cfg(32'h00C0_01FF, "R2");

    // R3 / R4: each port event alone, enabled then disabled
    for (int b = 0; b < 8; b++) begin
      set_cfg(32'h1 << (24 + b), "R3");
      pev = 8'h1 << b; step("R3");
      pev = ~(8'h1 << b); step("R4");
      quiet(); step("R10");
    end

    // R5: every mode, snoop = 5
    set_cfg((32'd1 << 21) | (32'd5 << 17), "R5");
    eot_alloc_vld = 1; eot_alloc_cls = 4'd5; step("R5");
    eot_alloc_cls = 4'd4; step("R5");
    eot_alloc_cls = 4'd5; step("R5");
    quiet(); step("R5");

    // R7: invalid codes never match
    set_cfg((32'd1 << 21) | (32'd9 << 17), "R7");
    eot_alloc_vld = 1; eot_alloc_cls = 4'd9; step("R7");
    set_cfg((32'd1 << 21), "R7");
    eot_alloc_vld = 1; eot_alloc_cls = 4'd0; step("R7");
    quiet();

    // R6: rolling mode, non-data response = 3, pulse on 128th match
    set_cfg(32'd3 << 17, "R6");
    for (int i = 1; i <= 128; i++) begin
      if (i % 10 == 0) begin
        eot_alloc_vld = 1; eot_alloc_cls = 4'd4; step("R6");
      end
      eot_alloc_vld = 1; eot_alloc_cls = 4'd3; step("R6");
      chk("R6", {31'd0, inc_pulse}, {31'd0, (i == 128)});
    end
    quiet(); step("R6");

    // R11: rewrite mid-count restarts the 128 window
    for (int i = 0; i < 100; i++) begin
      eot_alloc_vld = 1; eot_alloc_cls = 4'd3; step("R11");
    end
    set_cfg(32'd3 << 17, "R11");
    for (int i = 1; i <= 128; i++) begin
      eot_alloc_vld = 1; eot_alloc_cls = 4'd3; step("R11");
      chk("R11", {31'd0, inc_pulse}, {31'd0, (i == 128)});
    end
    quiet();
    // R11: write cycle uses old config
    set_cfg(32'h8000_0000, "R11");
    pev = 8'h80; cfg_we = 1; cfg_wdata = 32'h0; step("R11");
    cfg_we = 0; pev = 8'h80; step("R11");
    quiet();

    // R8: busy cycles
    set_cfg(32'd1 << 16, "R8");
    eot_busy = 1; step("R8"); step("R8");
    eot_busy = 0; step("R8");

    // R9: arbitration mask, bit 15 home VN0 = arb_alloc[6]
    set_cfg(32'h0000_8000, "R9");
    arb_alloc = 7'h40; step("R9");
    arb_alloc = 7'h3F; step("R9");
    quiet();
    set_cfg(32'h0000_0200, "R9");
    arb_alloc = 7'h01; step("R9");
    quiet();

    // R10: many sources in one cycle give one pulse, then it falls
    set_cfg(32'hFF3F_FE00 & ~(32'd1 << 21) | (32'd1 << 21), "R10");
    pev = 8'hFF; eot_busy = 1; arb_alloc = 7'h7F; step("R10");
    chk("R10", {31'd0, inc_pulse}, 32'd1);
    quiet(); step("R10");
    chk("R10", {31'd0, inc_pulse}, 32'd0);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      pev           = 8'($urandom & $urandom & $urandom);
      eot_busy      = ($urandom % 4 == 0);
      eot_alloc_vld = $urandom % 2;
      eot_alloc_cls = ($urandom % 2) ? m_cfg[20:17] : 4'($urandom);
      arb_alloc     = 7'($urandom & $urandom & $urandom);
      cfg_we        = ($urandom % 64 == 0);
      cfg_wdata     = $urandom & $urandom & $urandom;
      step("R10");
    end
    quiet();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule